// File: doc/BRIEF.md
# BCD Calendar Alarm Matcher

This block watches a live BCD calendar (second, minute, hour, day of month, weekday) and raises a sticky alarm flag when the calendar reaches a programmed moment. Each of the five alarm fields has its own disable bit. The match is the AND of only those fields that are enabled. This lets software build a daily alarm, an hourly alarm or a once-a-month alarm by leaving the unwanted fields out. If every field is disabled, no alarm can fire.

The calendar counter sits outside the block. It supplies the current BCD fields together with a one-cycle strobe at the start of each new second. The comparison is evaluated only on that strobe, so one matching second produces exactly one flag event. Software reaches the five alarm registers and a control register through a small synchronous write port and a combinational read port. An active-low interrupt line is asserted while the flag is set and the interrupt is enabled.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset the flag is 0, `irq_n` is 1, each alarm register reads 0x80 (field disabled, value 0) and the control register at 0x01 reads 0x00.
- R2: The alarm registers sit at 0x0A (second), 0x0B (minute), 0x0C (hour), 0x0D (day of month) and 0x0E (weekday). Bit 7 is the disable bit. The value keeps 7 bits for second and minute, 6 bits for hour and day of month, and 3 bits for weekday. Unused value bits read 0, so a write of 0xFF reads back 0xFF, 0xFF, 0xBF, 0xBF and 0x87.
- R3: The flag is set on the clock edge where `tick` is 1 and every enabled field equals its live counterpart. Without `tick`, or with any enabled field unequal, the flag does not set.
- R4: A field whose bit 7 is 1 takes no part in the comparison, whatever its live value.
- R5: When all five fields are disabled, a tick never sets the flag.
- R6: The flag is bit 4 of register 0x01. It stays set until a write to 0x01 with bit 4 at 0. A write with bit 4 at 1 neither sets nor clears it.
- R7: If a flag-clear write and a match tick occur in the same cycle, the flag is set afterwards.
- R8: Bit 1 of register 0x01 is the interrupt enable. `irq_n` is 0 exactly while the enable and the flag are both 1. Clearing the enable releases `irq_n` and leaves the flag unchanged.
- R9: After the flag has been cleared, a calendar that still matches does not set the flag again until the next `tick`.
- R10: An enabled weekday field takes part in the match on its 3 low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe at each new second |
| cur_sec | input | 7 | Live BCD seconds |
| cur_min | input | 7 | Live BCD minutes |
| cur_hour | input | 6 | Live BCD hours |
| cur_mday | input | 6 | Live BCD day of month |
| cur_wday | input | 3 | Live weekday |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Active-low level interrupt |

## Verification
A wrong stored alarm value or disable bit shows up in two places. It appears on `rdata` as soon as the register is addressed. It also shows in `alarm_flag` one edge after the first tick whose calendar should or should not match. A flag that sets or clears wrongly, or loses the same-cycle race with a clear, is visible on `alarm_flag` and `irq_n` on the next edge. Every flag event is therefore observed at the negative edge that follows the tick or the write that caused it.

// File: rtl/calm_pkg.sv
package calm_pkg;
    localparam int NFIELD  = 5;
    localparam int FW      = 7;
    localparam int AW      = 5;
    localparam int DW      = 8;
    localparam int IE_BIT  = 1;
    localparam int FLG_BIT = 4;
    localparam int DIS_BIT = 7;
    localparam logic [AW-1:0] CTRL_ADDR = 5'h01;
    localparam logic [AW-1:0] ALM_BASE  = 5'h0A;

    typedef logic [FW-1:0] fval_t;

    typedef struct packed {
        logic  dis;
        fval_t val;
    } alm_fld_t;

    typedef struct packed {
        logic set;
        logic clr;
    } flag_req_t;

    // compared width of field i: second, minute, hour, day of month, weekday
    function automatic int fwidth(input int i);
        case (i)
            0, 1:    return 7;
            2, 3:    return 6;
            default: return 3;
        endcase
    endfunction

    function automatic fval_t fmask(input int i);
        fval_t m;
        for (int b = 0; b < FW; b++) m[b] = (b < fwidth(i));
        return m;
    endfunction
endpackage

// File: rtl/calm_regs.sv
module calm_regs
    import calm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic            flag,
    output alm_fld_t        fld [NFIELD],
    output logic            ie,
    output logic            clr_req,
    output logic [DW-1:0]   rdata
);
    localparam alm_fld_t FLD_RST = '{dis: 1'b1, val: '0};

    logic ctrl_hit;
    assign ctrl_hit = (addr == CTRL_ADDR);

    for (genvar i = 0; i < NFIELD; i++) begin : g_fld
        localparam logic [AW-1:0] MY_ADDR = ALM_BASE + AW'(i);
        always_ff @(posedge clk) begin
            if (rst) begin
                fld[i] <= FLD_RST;
            end else if (wr_en && addr == MY_ADDR) begin
                fld[i].dis <= wdata[DIS_BIT];
                fld[i].val <= wdata[FW-1:0] & fmask(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                   ie <= 1'b0;
        else if (wr_en && ctrl_hit) ie <= wdata[IE_BIT];
    end

    assign clr_req = wr_en && ctrl_hit && !wdata[FLG_BIT];

    always_comb begin
        rdata = '0;
        if (ctrl_hit) begin
            rdata[IE_BIT]  = ie;
            rdata[FLG_BIT] = flag;
        end
        for (int i = 0; i < NFIELD; i++) begin
            if (addr == ALM_BASE + AW'(i)) rdata = {fld[i].dis, fld[i].val};
        end
    end
endmodule

// File: rtl/calm_field_cmp.sv
module calm_field_cmp
    import calm_pkg::*;
#(
    parameter int W = 7
) (
    input  logic [W-1:0] live,
    input  alm_fld_t     cfg,
    output logic         hit,
    output logic         used
);
    assign used = !cfg.dis;
    assign hit  = cfg.dis || (live == cfg.val[W-1:0]);
endmodule

// File: rtl/calm_flag.sv
module calm_flag
    import calm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      all_hit,
    input  logic      any_used,
    input  flag_req_t req,
    output logic      flag
);
    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (req.set) flag <= 1'b1;
        else if (req.clr) flag <= 1'b0;
    end

    // R3
    flag_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(tick));
    // R5
    flag_needs_field_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(any_used && all_hit));
    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && all_hit && any_used && req.clr) |=> flag);
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
    import calm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [6:0]    cur_sec,
    input  logic [6:0]    cur_min,
    input  logic [5:0]    cur_hour,
    input  logic [5:0]    cur_mday,
    input  logic [2:0]    cur_wday,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          alarm_flag,
    output logic          irq_n
);
    alm_fld_t    fld [NFIELD];
    fval_t       live [NFIELD];
    logic [NFIELD-1:0] hit, used;
    logic        ie, clr_req, all_hit, any_used;
    flag_req_t   req;

    assign live[0] = FW'(cur_sec);
    assign live[1] = FW'(cur_min);
    assign live[2] = FW'(cur_hour);
    assign live[3] = FW'(cur_mday);
    assign live[4] = FW'(cur_wday);

    calm_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .flag(alarm_flag), .fld(fld), .ie(ie), .clr_req(clr_req), .rdata(rdata)
    );

    for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
        localparam int W = fwidth(i);
        calm_field_cmp #(.W(W)) u_cmp (
            .live(live[i][W-1:0]), .cfg(fld[i]), .hit(hit[i]), .used(used[i])
        );
    end

    assign all_hit  = &hit;
    assign any_used = |used;
    assign req.set  = tick && all_hit && any_used;
    assign req.clr  = clr_req;

    calm_flag u_flag (
        .clk(clk), .rst(rst), .tick(tick), .all_hit(all_hit),
        .any_used(any_used), .req(req), .flag(alarm_flag)
    );

    assign irq_n = !(ie && alarm_flag);

    // R6
    flag_clear_by_write_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(alarm_flag) |-> $past(wr_en && addr == CTRL_ADDR && !wdata[FLG_BIT]));
    // R8
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_n) |-> (ie && alarm_flag));
endmodule

// File: tb/cal_alarm_match_bench.sv
module cal_alarm_match_bench;
    logic clk = 0, rst = 1, tick = 0, wr_en = 0;
    logic [6:0] cur_sec = 0, cur_min = 0;
    logic [5:0] cur_hour = 0, cur_mday = 0;
    logic [2:0] cur_wday = 0;
    logic [4:0] addr = 0;
    logic [7:0] wdata = 0, rdata;
    logic alarm_flag, irq_n;
    int vecs = 0, bad = 0;

    always #10 clk = ~clk;

    cal_alarm_match u_cal_alarm_match (
        .clk(clk), .rst(rst), .tick(tick), .cur_sec(cur_sec), .cur_min(cur_min),
        .cur_hour(cur_hour), .cur_mday(cur_mday), .cur_wday(cur_wday),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .alarm_flag(alarm_flag), .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        vecs++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
        addr = a; #1;
        chk(req, rdata, exp);
    endtask

    task automatic do_tick();
        tick = 1;
        @(negedge clk);
        tick = 0;
    endtask

    task automatic set_time(input logic [6:0] s, input logic [6:0] m,
                            input logic [5:0] h, input logic [5:0] d, input logic [2:0] w);
        cur_sec = s; cur_min = m; cur_hour = h; cur_mday = d; cur_wday = w;
    endtask

    task automatic t_reset();
        chk("R1 flag", {7'd0, alarm_flag}, 8'd0);
        chk("R1 irq_n", {7'd0, irq_n}, 8'd1);
        for (int i = 0; i < 5; i++) rd_chk("R1 alarm reg", 5'h0A + 5'(i), 8'h80);
        rd_chk("R1 ctrl", 5'h01, 8'h00);
    endtask

    task automatic t_regs();
        for (int i = 0; i < 5; i++) wr(5'h0A + 5'(i), 8'hFF);
        rd_chk("R2 sec", 5'h0A, 8'hFF);
        rd_chk("R2 min", 5'h0B, 8'hFF);
        rd_chk("R2 hour", 5'h0C, 8'hBF);
        rd_chk("R2 mday", 5'h0D, 8'hBF);
        rd_chk("R2 wday", 5'h0E, 8'h87);
        wr(5'h0C, 8'h23);
        rd_chk("R2 hour value", 5'h0C, 8'h23);
    endtask

    task automatic t_match();
        wr(5'h0A, 8'h30); wr(5'h0B, 8'h15); wr(5'h0C, 8'h09);
        wr(5'h0D, 8'h21); wr(5'h0E, 8'h80);
        set_time(7'h30, 7'h15, 6'h09, 6'h21, 3'd6);
        @(negedge clk); @(negedge clk);
        chk("R3 no tick", {7'd0, alarm_flag}, 8'd0);
        do_tick();
        chk("R3 match", {7'd0, alarm_flag}, 8'd1);
        chk("R8 ie off", {7'd0, irq_n}, 8'd1);
        rd_chk("R6 flag bit", 5'h01, 8'h10);
        wr(5'h01, 8'h10);
        chk("R6 write one keeps", {7'd0, alarm_flag}, 8'd1);
        wr(5'h01, 8'h00);
        chk("R6 cleared", {7'd0, alarm_flag}, 8'd0);
        wr(5'h01, 8'h10);
        chk("R6 write one no set", {7'd0, alarm_flag}, 8'd0);
        repeat (3) @(negedge clk);
        chk("R9 no retrigger", {7'd0, alarm_flag}, 8'd0);
        set_time(7'h31, 7'h15, 6'h09, 6'h21, 3'd6);
        do_tick();
        chk("R3 mismatch sec", {7'd0, alarm_flag}, 8'd0);
        set_time(7'h30, 7'h15, 6'h08, 6'h21, 3'd6);
        do_tick();
        chk("R3 mismatch hour", {7'd0, alarm_flag}, 8'd0);
    endtask

    task automatic t_disabled();
        wr(5'h0A, 8'hB0);
        set_time(7'h59, 7'h15, 6'h09, 6'h21, 3'd2);
        do_tick();
        chk("R4 sec ignored", {7'd0, alarm_flag}, 8'd1);
        wr(5'h01, 8'h00);
        wr(5'h0E, 8'h0B);
        rd_chk("R10 wday masked", 5'h0E, 8'h03);
        do_tick();
        chk("R10 wday mismatch", {7'd0, alarm_flag}, 8'd0);
        cur_wday = 3'd3;
        do_tick();
        chk("R10 wday match", {7'd0, alarm_flag}, 8'd1);
        wr(5'h01, 8'h00);
    endtask

    task automatic t_irq();
        wr(5'h01, 8'h02);
        chk("R8 enable only", {7'd0, irq_n}, 8'd1);
        do_tick();
        chk("R8 irq asserted", {7'd0, irq_n}, 8'd0);
        rd_chk("R8 ctrl read", 5'h01, 8'h12);
        wr(5'h01, 8'h10);
        chk("R8 irq released", {7'd0, irq_n}, 8'd1);
        chk("R8 flag kept", {7'd0, alarm_flag}, 8'd1);
        wr(5'h01, 8'h00);
    endtask

    task automatic t_same_cycle();
        addr = 5'h01; wdata = 8'h00; wr_en = 1; tick = 1;
        @(negedge clk);
        wr_en = 0; tick = 0;
        chk("R7 set wins", {7'd0, alarm_flag}, 8'd1);
        wr(5'h01, 8'h00);
    endtask

    task automatic t_all_disabled();
        for (int i = 0; i < 5; i++) wr(5'h0A + 5'(i), 8'h80);
        do_tick();
        chk("R5 all disabled", {7'd0, alarm_flag}, 8'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_match();
        t_disabled();
        t_irq();
        t_same_cycle();
        t_all_disabled();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule